// File: doc/BRIEF.md
# Single-Channel Block Copy Engine

This block moves a run of bytes from one memory region to another without the processor touching the data. Software loads a source address, a destination address and a byte count through a small four-word register window, then sets a go bit. The engine asks an external arbiter for the memory bus and holds that request for the whole transfer. While it owns the bus, the processor is locked out. Each byte moves through a read followed by a write on a simple single-beat master port.

The device at the far end paces the copy. A byte is started only when the device holds its request line high, and the engine answers each byte with a one-cycle acknowledge pulse. When the count runs out, the engine releases the bus and raises an interrupt. The interrupt stays high until software clears it. A zero count completes at once and never requests the bus.

Top module: `dma_ctrl`

## Requirements
- R1: After synchronous reset, irq, bus_req, dma_ack, mem_rd and mem_wr are low, and every register reads back as zero.
- R2: Register index 0 holds the source address, index 1 the destination address, index 2 the byte count and index 3 control/status. Reads return data on reg_rdata in the cycle after reg_re. Indexes 0 to 2 read back the live working values. At index 3, status bit 0 is busy and bit 1 is done.
- R3: A write to index 3 with bit 0 set while the engine is idle starts a transfer, and status bit 0 reads 1 until the transfer finishes.
- R4: A transfer of N bytes copies the bytes at source..source+N-1 to destination..destination+N-1 using exactly 2N memory cycles. Afterwards, source and destination read back advanced by N, the count reads back 0, and the byte after the destination region is untouched.
- R5: bus_req stays high from start until the last byte is written. No memory cycle is issued unless bus_gnt was high in the cycle before, and every memory cycle occurs while bus_req is high.
- R6: A byte read starts only in the cycle after dma_req was sampled high. dma_ack pulses for exactly one cycle per byte, giving N pulses for N bytes.
- R7: Starting with a count of zero sets done and raises irq without asserting bus_req and without any memory cycle.
- R8: irq rises only on completion and stays high until a write to index 3 with bit 1 set. A write to index 3 with bit 1 clear leaves it high.
- R9: While busy, writes to indexes 0 to 2 and further start requests are ignored, so the running copy completes exactly as first programmed.
- R10: mem_rd and mem_wr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | RW | Register write data |
| reg_rdata | output | RW | Registered read data |
| irq | output | 1 | Completion interrupt, level |
| dma_req | input | 1 | Device ready for one byte |
| dma_ack | output | 1 | One-cycle pulse per byte moved |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid one cycle after mem_rd |

## Verification
The assertions check the bus-protocol rules on every cycle:
- a read never starts without grant and device request in the prior cycle;
- read and write strobes never overlap;
- the acknowledge is a single-cycle pulse;
- memory cycles occur only while the bus is requested;
- the interrupt holds until cleared;
- a zero count finishes without touching the bus.

Only the bench scenarios can show that:
- the right bytes land at the right addresses;
- the addresses and count advance by exactly the transfer length;
- the pulse total matches the count;
- writes made while busy leave the running copy unchanged.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RD,
    ST_CAP,
    ST_WR
  } dma_state_e;

  localparam logic [1:0] IDX_SRC = 2'd0;
  localparam logic [1:0] IDX_DST = 2'd1;
  localparam logic [1:0] IDX_CNT = 2'd2;
  localparam logic [1:0] IDX_CSR = 2'd3;

  localparam int CSR_GO   = 0;
  localparam int CSR_DONE = 1;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int RW = 16,
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [1:0]    reg_addr,
  input  logic [RW-1:0] reg_wdata,
  input  logic          busy,
  input  logic          finish,
  input  logic [AW-1:0] cur_src,
  input  logic [AW-1:0] cur_dst,
  input  logic [CW-1:0] cur_cnt,
  output logic          ld_src,
  output logic          ld_dst,
  output logic          ld_cnt,
  output logic          go,
  output logic [RW-1:0] reg_rdata,
  output logic          irq
);
  logic done_q;
  logic clr_done;

  // Loads and start are only honoured while idle.
  assign ld_src   = reg_we && (reg_addr == IDX_SRC) && !busy;
  assign ld_dst   = reg_we && (reg_addr == IDX_DST) && !busy;
  assign ld_cnt   = reg_we && (reg_addr == IDX_CNT) && !busy;
  assign go       = reg_we && (reg_addr == IDX_CSR) && reg_wdata[CSR_GO] && !busy;
  assign clr_done = reg_we && (reg_addr == IDX_CSR) && reg_wdata[CSR_DONE];

  always_ff @(posedge clk) begin
    if (rst) done_q <= 1'b0;
    else if (finish) done_q <= 1'b1;
    else if (clr_done) done_q <= 1'b0;
  end

  assign irq = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_re) begin
      unique case (reg_addr)
        IDX_SRC: reg_rdata <= RW'(cur_src);
        IDX_DST: reg_rdata <= RW'(cur_dst);
        IDX_CNT: reg_rdata <= RW'(cur_cnt);
        default: begin
          reg_rdata           <= '0;
          reg_rdata[CSR_GO]   <= busy;
          reg_rdata[CSR_DONE] <= done_q;
        end
      endcase
    end
  end

  // R8: interrupt holds until software clears it
  assert_irq_hold_R8: assert property (@(posedge clk) disable iff (rst)
    irq && !clr_done |=> irq);
  // R8: interrupt rises only after a completion
  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(finish));
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 8,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_src,
  input  logic          ld_dst,
  input  logic          ld_cnt,
  input  logic          go,
  input  logic [RW-1:0] ld_data,
  input  logic          dma_req,
  input  logic          bus_gnt,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          finish,
  output logic [AW-1:0] cur_src,
  output logic [AW-1:0] cur_dst,
  output logic [CW-1:0] cur_cnt,
  output logic          dma_ack,
  output logic          bus_req,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  dma_state_e state;

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cur_src   <= '0;
      cur_dst   <= '0;
      cur_cnt   <= '0;
      finish    <= 1'b0;
      dma_ack   <= 1'b0;
      bus_req   <= 1'b0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      finish <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (ld_src) cur_src <= ld_data[AW-1:0];
          if (ld_dst) cur_dst <= ld_data[AW-1:0];
          if (ld_cnt) cur_cnt <= ld_data[CW-1:0];
          if (go) begin
            if (cur_cnt == '0) begin
              finish <= 1'b1;
            end else begin
              bus_req <= 1'b1;
              state   <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (bus_gnt && dma_req) begin
            mem_rd   <= 1'b1;
            mem_addr <= cur_src;
            state    <= ST_RD;
          end
        end
        ST_RD: begin
          mem_rd <= 1'b0;
          state  <= ST_CAP;
        end
        ST_CAP: begin
          mem_wr    <= 1'b1;
          mem_addr  <= cur_dst;
          mem_wdata <= mem_rdata;
          dma_ack   <= 1'b1;
          state     <= ST_WR;
        end
        ST_WR: begin
          mem_wr  <= 1'b0;
          dma_ack <= 1'b0;
          cur_src <= cur_src + AW'(1);
          cur_dst <= cur_dst + AW'(1);
          cur_cnt <= cur_cnt - CNT_ONE;
          if (cur_cnt == CNT_ONE) begin
            bus_req <= 1'b0;
            finish  <= 1'b1;
            state   <= ST_IDLE;
          end else begin
            state <= ST_WAIT;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5, R6: a read needs grant and device request in the previous cycle
  assert_rd_needs_gnt_R5: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> $past(bus_gnt) && $past(dma_req));
  // R5: memory cycles only while the bus is requested
  assert_ops_owned_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr) |-> bus_req);
  // R6: acknowledge is a one-cycle pulse
  assert_ack_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    dma_ack |=> !dma_ack);
  // R7: a zero count completes without requesting the bus
  assert_zero_count_R7: assert property (@(posedge clk) disable iff (rst)
    go && (cur_cnt == '0) |=> finish && !bus_req);
  // R10: never read and write at once
  assert_no_rw_overlap_R10: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 8,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [1:0]    reg_addr,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  output logic          irq,
  input  logic          dma_req,
  output logic          dma_ack,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  logic          busy, finish, ld_src, ld_dst, ld_cnt, go;
  logic [AW-1:0] cur_src, cur_dst;
  logic [CW-1:0] cur_cnt;

  dma_regs #(.RW(RW), .AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst(rst),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .busy(busy), .finish(finish),
    .cur_src(cur_src), .cur_dst(cur_dst), .cur_cnt(cur_cnt),
    .ld_src(ld_src), .ld_dst(ld_dst), .ld_cnt(ld_cnt), .go(go),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  dma_engine #(.AW(AW), .CW(CW), .DW(DW), .RW(RW)) u_engine (
    .clk(clk), .rst(rst),
    .ld_src(ld_src), .ld_dst(ld_dst), .ld_cnt(ld_cnt), .go(go),
    .ld_data(reg_wdata),
    .dma_req(dma_req), .bus_gnt(bus_gnt), .mem_rdata(mem_rdata),
    .busy(busy), .finish(finish),
    .cur_src(cur_src), .cur_dst(cur_dst), .cur_cnt(cur_cnt),
    .dma_ack(dma_ack), .bus_req(bus_req),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );
endmodule

// File: tb/tb_dma_ctrl.sv
`timescale 1ns/1ps
module tb_dma_ctrl;
  localparam int AW = 16, CW = 16, DW = 8, RW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [RW-1:0] reg_wdata = '0;
  logic [RW-1:0] reg_rdata;
  logic irq, dma_ack, bus_req, mem_rd, mem_wr;
  logic dma_req = 1'b0, bus_gnt = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;

  always #4 clk = ~clk;

  dma_ctrl #(.AW(AW), .CW(CW), .DW(DW), .RW(RW)) dut (.*);

  int checks = 0, fails = 0;
  int dack_cnt = 0, ops_cnt = 0, breq_cnt = 0, viol = 0;
  logic prev_ok = 1'b0;
  bit gnt_block = 0, dreq_on = 1;
  int dreq_pct = 100;
  logic [7:0] mem [256];

  // Memory model: synchronous read, one-cycle latency.
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
  end

  // Bus monitor: samples pre-edge values (inputs change on negedge).
  always @(posedge clk) begin
    if (!rst) begin
      if (dma_ack) dack_cnt++;
      if (mem_rd || mem_wr) ops_cnt++;
      if (bus_req) breq_cnt++;
      if (mem_rd && !prev_ok) viol++;
      if ((mem_rd || mem_wr) && !bus_req) viol++;
    end
    prev_ok = bus_gnt && dma_req;
  end

  // Arbiter and device stimulus.
  always @(negedge clk) begin
    if (!bus_req || gnt_block) bus_gnt = 1'b0;
    else if ($urandom % 3 == 0) bus_gnt = 1'b1;
    dma_req = dreq_on && (($urandom % 100) < dreq_pct);
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [RW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [RW-1:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 6000 && !irq; i++) @(negedge clk);
  endtask

  // Full transfer with checks; poke issues writes while busy (R9).
  task automatic xfer(input int src, input int dst, input int n, input bit poke);
    logic [7:0] expb [64];
    logic [7:0] guard;
    logic [RW-1:0] v;
    int d0, o0;
    for (int i = 0; i < n; i++) expb[i] = mem[(src + i) % 256];
    guard = mem[(dst + n) % 256];
    d0 = dack_cnt; o0 = ops_cnt;
    wr(2'd0, RW'(src)); wr(2'd1, RW'(dst)); wr(2'd2, RW'(n)); wr(2'd3, 16'h0001);
    rd(2'd3, v);
    chk("R3 busy after start", {31'd0, v[0]}, 32'd1);
    if (poke) begin
      repeat (6) @(negedge clk);
      wr(2'd0, 16'd200); wr(2'd1, 16'd250); wr(2'd2, 16'd3); wr(2'd3, 16'h0001);
    end
    wait_irq();
    chk("R8 irq on completion", {31'd0, irq}, 32'd1);
    chk("R6 ack pulses", dack_cnt - d0, n);
    chk("R4 memory cycles", ops_cnt - o0, 2 * n);
    for (int i = 0; i < n; i++)
      chk(poke ? "R9 copy unchanged" : "R4 copied byte", mem[(dst + i) % 256], expb[i]);
    chk("R4 guard byte", mem[(dst + n) % 256], guard);
    rd(2'd0, v); chk("R4 src advanced", v, RW'(src + n));
    rd(2'd1, v); chk("R4 dst advanced", v, RW'(dst + n));
    rd(2'd2, v); chk("R4 count zero", v, 0);
    rd(2'd3, v); chk("R2 status done idle", v, 2);
    chk("R5 bus released", {31'd0, bus_req}, 0);
    wr(2'd3, 16'h0000);
    chk("R8 irq held on write without clear", {31'd0, irq}, 1);
    wr(2'd3, 16'h0002);
    chk("R8 irq cleared", {31'd0, irq}, 0);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [RW-1:0] v;
    int o0, b0;
    void'($urandom(32'd20201));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 bus_req", {31'd0, bus_req}, 0);
    chk("R1 strobes", {29'd0, dma_ack, mem_rd, mem_wr}, 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R1 register zero", v, 0);
    end

    // R2 directed: single byte, full device request
    xfer(10, 130, 1, 0);
    // R7 zero count
    o0 = ops_cnt; b0 = breq_cnt;
    wr(2'd2, 16'd0); wr(2'd3, 16'h0001);
    repeat (2) @(negedge clk);
    chk("R7 irq on zero count", {31'd0, irq}, 1);
    chk("R7 no memory cycles", ops_cnt - o0, 0);
    chk("R7 no bus request", breq_cnt - b0, 0);
    wr(2'd3, 16'h0002);

    // R5 grant withheld: nothing moves
    gnt_block = 1;
    wr(2'd0, 16'd20); wr(2'd1, 16'd140); wr(2'd2, 16'd4);
    o0 = ops_cnt;
    wr(2'd3, 16'h0001);
    repeat (30) @(negedge clk);
    chk("R5 bus_req held", {31'd0, bus_req}, 1);
    chk("R5 no cycles without grant", ops_cnt - o0, 0);
    rd(2'd2, v); chk("R5 count unchanged", v, 4);
    gnt_block = 0;
    wait_irq();
    chk("R5 completes after grant", {31'd0, irq}, 1);
    wr(2'd3, 16'h0002);

    // R6 device request withheld
    dreq_on = 0;
    wr(2'd0, 16'd30); wr(2'd1, 16'd150); wr(2'd2, 16'd2);
    o0 = ops_cnt;
    wr(2'd3, 16'h0001);
    repeat (25) @(negedge clk);
    chk("R6 no cycles without request", ops_cnt - o0, 0);
    dreq_on = 1;
    wait_irq();
    wr(2'd3, 16'h0002);

    // R9 writes while busy ignored
    dreq_pct = 60;
    xfer(5, 170, 30, 1);

    // Random transfers
    for (int k = 0; k < 8; k++) begin
      dreq_pct = 30 + int'($urandom % 71);
      xfer(int'($urandom % 64), 128 + int'($urandom % 64), 1 + int'($urandom % 40), 0);
    end
    // Boundary: longest buffer
    dreq_pct = 100;
    xfer(0, 128, 63, 0);

    chk("R5 R6 R10 protocol violations", viol, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule